// File: doc/BRIEF.md
# Hibernate Wakeup and Reset Sequencer

This block sequences power for the always-on timekeeping domain of a chip. It runs on the fast system clock and advances only on a single-cycle slow tick enable, nominally at 32 kHz. Software enters hibernate with a register write, and the power-enable output falls. While the chip is down, the block watches an external wake pin. It wakes only when the pin has been seen high on enough consecutive ticks, so short glitches on the pin do not wake the chip.

On waking, power-enable returns high. The system reset output is then held low for a programmed number of ticks so that the supplies can settle before the rest of the chip leaves reset. Both durations are programmed through small register fields that count in steps of 32 ticks. At the default widths, the wake debounce window reaches about 2 s and the reset pulse reaches about 125 ms.

Top module: `hibernate_seq`

## Requirements
- R1: After reset, `pwr_en` is 1, `sys_rst_n` is 1, and both count registers read 0.
- R2: A write to offset 0x20 with data bit 0 set, made while running, drives `pwr_en` low from the next cycle. A write there with bit 0 clear has no effect.
- R3: The debounce register (offset 0x24) keeps only data bits 15:5, and the reset-pulse register (offset 0x28) keeps only bits 11:5. All other bits read 0, and offset 0x20 reads 0.
- R4: While hibernating, `pwr_en` rises on the Nth consecutive tick on which `wake_pin` is sampled high, where N is the debounce register value.
- R5: A tick that samples `wake_pin` low before the window completes discards the count, even on the tick that would have been the Nth. A later wake needs N fresh consecutive high ticks.
- R6: With a pulse value of M>0, `sys_rst_n` goes low on the waking tick and returns high on the Mth tick after it.
- R7: A debounce value of 0 wakes on the first tick that sees the pin high. A pulse value of 0 wakes straight to running, so `sys_rst_n` never goes low.
- R8: `pwr_en` is low only while hibernating or debouncing. `sys_rst_n` is never low while `pwr_en` is low.
- R9: Cycles without a tick do not advance the sequence. The pin is ignored on those cycles.
- R10: A hibernate write made during the reset pulse is ignored, and the pulse length is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous block reset |
| tick_en | input | 1 | One-cycle slow tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write offset |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read offset |
| rd_data | output | DATA_W | Read data, combinational |
| wake_pin | input | 1 | External wake request, active high |
| pwr_en | output | 1 | Power enable for the switched domain |
| sys_rst_n | output | 1 | Active-low system reset |

## Verification
Ending the debounce window and discarding it can fall on the same tick: the tick that would complete the window may sample the pin low. The bench provokes this by holding the pin high for N-1 ticks and dropping it exactly on the Nth. The discard must win, so `pwr_en` stays low. The bench then shows the count really restarted: the wake must take a full N further high ticks and must not come one tick early. A hibernate write that lands during the reset pulse is also checked, by confirming the pulse length stays the same.

// File: rtl/hibseq_pkg.sv
package hibseq_pkg;
   typedef enum logic [1:0] {
      SEQ_RUN    = 2'd0,
      SEQ_SLEEP  = 2'd1,
      SEQ_DEBNC  = 2'd2,
      SEQ_HOLD   = 2'd3
   } seq_state_e;
endpackage

// File: rtl/hibseq_regs.sv
module hibseq_regs #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned DEB_MSB  = 15,
   parameter int unsigned PUL_MSB  = 11,
   parameter int unsigned GRAN_LSB = 5,
   parameter int unsigned CNT_W    = 16,
   parameter logic [ADDR_W-1:0] HIB_OFS = 'h20,
   parameter logic [ADDR_W-1:0] DEB_OFS = 'h24,
   parameter logic [ADDR_W-1:0] PUL_OFS = 'h28
) (
   input  logic              clk,
   input  logic              rst_ni,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              hib_req,
   output logic [CNT_W-1:0]  deb_lim,
   output logic [CNT_W-1:0]  pul_lim
);
   localparam int unsigned DEB_BITS = DEB_MSB - GRAN_LSB + 1;
   localparam int unsigned PUL_BITS = PUL_MSB - GRAN_LSB + 1;

   logic [DEB_BITS-1:0] deb_q;
   logic [PUL_BITS-1:0] pul_q;
   logic [DATA_W-1:0]   deb_word, pul_word;

   always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
         deb_q <= '0;
         pul_q <= '0;
      end else if (wr_en) begin
         if (wr_addr == DEB_OFS) deb_q <= wr_data[DEB_MSB:GRAN_LSB];
         if (wr_addr == PUL_OFS) pul_q <= wr_data[PUL_MSB:GRAN_LSB];
      end
   end

   always_comb begin
      deb_word = '0;
      pul_word = '0;
      deb_word[DEB_MSB:GRAN_LSB] = deb_q;
      pul_word[PUL_MSB:GRAN_LSB] = pul_q;
   end

   assign hib_req = wr_en && (wr_addr == HIB_OFS) && wr_data[0];
   assign deb_lim = deb_word[CNT_W-1:0];
   assign pul_lim = pul_word[CNT_W-1:0];

   always_comb begin
      if (rd_addr == DEB_OFS)      rd_data = deb_word;
      else if (rd_addr == PUL_OFS) rd_data = pul_word;
      else                         rd_data = '0;
   end
endmodule

// File: rtl/hibseq_sync.sv
module hibseq_sync #(
   parameter int unsigned STAGES = 0
) (
   input  logic clk,
   input  logic rst_ni,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '0;
            else         chain_q <= {chain_q[STAGES-2:0], din};
         end
         assign dout = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/hibseq_fsm.sv
module hibseq_fsm
   import hibseq_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_ni,
   input  logic             tick_en,
   input  logic             pin,
   input  logic             hib_req,
   input  logic [CNT_W-1:0] deb_lim,
   input  logic [CNT_W-1:0] pul_lim,
   output logic             pwr_en,
   output logic             sys_rst_n
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   seq_state_e       st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
   seq_state_e       wake_st;

   assign cnt_inc = cnt_q + ONE;
   assign wake_st = (pul_lim == '0) ? SEQ_RUN : SEQ_HOLD;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      unique case (st_q)
         SEQ_RUN: begin
            if (hib_req) begin
               st_d  = SEQ_SLEEP;
               cnt_d = '0;
            end
         end
         SEQ_SLEEP: begin
            if (tick_en && pin) begin
               if (deb_lim <= ONE) begin
                  st_d  = wake_st;
                  cnt_d = '0;
               end else begin
                  st_d  = SEQ_DEBNC;
                  cnt_d = ONE;
               end
            end
         end
         SEQ_DEBNC: begin
            if (tick_en) begin
               if (!pin) begin
                  st_d  = SEQ_SLEEP;
                  cnt_d = '0;
               end else if (cnt_inc >= deb_lim) begin
                  st_d  = wake_st;
                  cnt_d = '0;
               end else begin
                  cnt_d = cnt_inc;
               end
            end
         end
         SEQ_HOLD: begin
            if (tick_en) begin
               if (cnt_inc >= pul_lim) begin
                  st_d  = SEQ_RUN;
                  cnt_d = '0;
               end else begin
                  cnt_d = cnt_inc;
               end
            end
         end
         default: begin
            st_d  = SEQ_RUN;
            cnt_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= SEQ_RUN;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   assign pwr_en    = (st_q == SEQ_RUN) || (st_q == SEQ_HOLD);
   assign sys_rst_n = (st_q != SEQ_HOLD);
endmodule

// File: rtl/hibernate_seq.sv
module hibernate_seq #(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned DEB_MSB     = 15,
   parameter int unsigned PUL_MSB     = 11,
   parameter int unsigned GRAN_LSB    = 5,
   parameter int unsigned SYNC_STAGES = 0,
   parameter logic [ADDR_W-1:0] HIB_OFS = 'h20,
   parameter logic [ADDR_W-1:0] DEB_OFS = 'h24,
   parameter logic [ADDR_W-1:0] PUL_OFS = 'h28
) (
   input  logic              clk,
   input  logic              rst_ni,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wake_pin,
   output logic              pwr_en,
   output logic              sys_rst_n
);
   localparam int unsigned CNT_W = ((DEB_MSB > PUL_MSB) ? DEB_MSB : PUL_MSB) + 1;

   generate
      if (CNT_W > DATA_W) begin : g_bad_width
         $error("count field exceeds data width");
      end
      if (GRAN_LSB < 1 || GRAN_LSB > PUL_MSB || GRAN_LSB > DEB_MSB) begin : g_bad_gran
         $error("granule position out of range");
      end
      if (SYNC_STAGES == 1) begin : g_bad_sync
         $error("synchronizer needs 0 or at least 2 stages");
      end
   endgenerate

   logic             hib_req, pin_s;
   logic [CNT_W-1:0] deb_lim, pul_lim;

   hibseq_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEB_MSB(DEB_MSB), .PUL_MSB(PUL_MSB),
      .GRAN_LSB(GRAN_LSB), .CNT_W(CNT_W),
      .HIB_OFS(HIB_OFS), .DEB_OFS(DEB_OFS), .PUL_OFS(PUL_OFS)
   ) u_regs (
      .clk(clk), .rst_ni(rst_ni), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .hib_req(hib_req), .deb_lim(deb_lim), .pul_lim(pul_lim)
   );

   hibseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_ni(rst_ni), .din(wake_pin), .dout(pin_s)
   );

   hibseq_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk(clk), .rst_ni(rst_ni), .tick_en(tick_en), .pin(pin_s),
      .hib_req(hib_req), .deb_lim(deb_lim), .pul_lim(pul_lim),
      .pwr_en(pwr_en), .sys_rst_n(sys_rst_n)
   );
endmodule

// File: rtl/hibernate_seq_chk.sv
module hibernate_seq_chk #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned GRAN_LSB = 5,
   parameter logic [ADDR_W-1:0] HIB_OFS = 'h20,
   parameter logic [ADDR_W-1:0] DEB_OFS = 'h24,
   parameter logic [ADDR_W-1:0] PUL_OFS = 'h28
) (
   input logic              clk,
   input logic              rst_ni,
   input logic              tick_en,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic              wake_pin,
   input logic              pwr_en,
   input logic              sys_rst_n
);
   logic hib_wr;
   assign hib_wr = wr_en && (wr_addr == HIB_OFS) && wr_data[0];

   p_rst_only_powered_r8: assert property (@(posedge clk) disable iff (!rst_ni)
      !sys_rst_n |-> pwr_en);

   p_enter_sleep_r2: assert property (@(posedge clk) disable iff (!rst_ni)
      (hib_wr && pwr_en && sys_rst_n) |=> !pwr_en);

   p_idle_no_move_r9: assert property (@(posedge clk) disable iff (!rst_ni)
      (!tick_en && !hib_wr) |=> ($stable(pwr_en) && $stable(sys_rst_n)));

   p_wake_on_pin_tick_r4: assert property (@(posedge clk) disable iff (!rst_ni)
      $rose(pwr_en) |-> ($past(tick_en) && $past(wake_pin)));

   p_release_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_ni)
      $rose(sys_rst_n) |-> $past(tick_en));

   p_low_bits_zero_r3: assert property (@(posedge clk) disable iff (!rst_ni)
      ((rd_addr == DEB_OFS) || (rd_addr == PUL_OFS)) |-> (rd_data[GRAN_LSB-1:0] == '0));
endmodule

bind hibernate_seq hibernate_seq_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GRAN_LSB(GRAN_LSB),
   .HIB_OFS(HIB_OFS), .DEB_OFS(DEB_OFS), .PUL_OFS(PUL_OFS)
) u_chk (
   .clk(clk), .rst_ni(rst_ni), .tick_en(tick_en), .wr_en(wr_en),
   .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
   .wake_pin(wake_pin), .pwr_en(pwr_en), .sys_rst_n(sys_rst_n)
);

// File: tb/hibernate_seq_bench.sv
module hibernate_seq_bench;
   logic        clk = 1'b0;
   logic        rst_ni = 1'b0;
   logic        tick_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        wake_pin = 1'b0;
   logic        pwr_en, sys_rst_n;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   typedef struct {
      logic  pwr;
      logic  rstn;
      string req;
   } exp_t;
   exp_t exp_q[$];

   always #5 clk = ~clk;

   hibernate_seq u_hibernate_seq (
      .clk(clk), .rst_ni(rst_ni), .tick_en(tick_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .wake_pin(wake_pin), .pwr_en(pwr_en), .sys_rst_n(sys_rst_n)
   );

   task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic push(input logic p, input logic r, input string req);
      exp_t e;
      e.pwr = p; e.rstn = r; e.req = req;
      exp_q.push_back(e);
   endtask

   // monitor: compare outputs against queued expectations, away from the edge
   initial begin
      forever begin
         @(negedge clk);
         while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check32({e.req, " pwr_en"}, {31'd0, pwr_en}, {31'd0, e.pwr});
            check32({e.req, " sys_rst_n"}, {31'd0, sys_rst_n}, {31'd0, e.rstn});
         end
      end
   end

   task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic reg_read(input logic [7:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      rd_addr = a;
      #1;
      check32(req, rd_data, exp);
   endtask

   task automatic do_tick(input logic pin, input logic p, input logic r, input string req);
      @(negedge clk);
      tick_en = 1'b1; wake_pin = pin;
      @(posedge clk); #1;
      tick_en = 1'b0;
      push(p, r, req);
   endtask

   task automatic enter_sleep();
      reg_write(8'h20, 32'h1);
      push(1'b0, 1'b1, "R2 enter");
   endtask

   // pin high for n ticks, wake expected on tick n (n>=1)
   task automatic debounce(input int n, input logic rst_low, input string req);
      for (int i = 1; i < n; i++) do_tick(1'b1, 1'b0, 1'b1, req);
      do_tick(1'b1, 1'b1, ~rst_low, req);
   endtask

   // m ticks of reset pulse, release on tick m
   task automatic pulse(input int m, input string req);
      for (int j = 1; j < m; j++) do_tick(1'b0, 1'b1, 1'b0, req);
      do_tick(1'b0, 1'b1, 1'b1, req);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_ni = 1'b1;
      // R1 reset state
      push(1'b1, 1'b1, "R1 reset");
      reg_read(8'h24, 32'h0, "R1 deb reg");
      reg_read(8'h28, 32'h0, "R1 pul reg");

      // R3 field masks
      reg_write(8'h24, 32'hFFFF_FFFF);
      reg_write(8'h28, 32'hFFFF_FFFF);
      reg_read(8'h24, 32'h0000_FFE0, "R3 deb mask");
      reg_read(8'h28, 32'h0000_0FE0, "R3 pul mask");
      reg_write(8'h24, 32'h1234_5678);
      reg_read(8'h24, 32'h1234_5678 & 32'h0000_FFE0, "R3 deb pattern");
      reg_read(8'h20, 32'h0, "R3 hib reads zero");

      // program 64-tick debounce, 32-tick pulse
      reg_write(8'h24, 32'd64);
      reg_write(8'h28, 32'd32);

      // R2 write with bit 0 clear ignored
      reg_write(8'h20, 32'hFFFF_FFFE);
      push(1'b1, 1'b1, "R2 bit0 clear");
      enter_sleep();

      // R4 pin low ticks keep sleeping
      for (int k = 0; k < 4; k++) do_tick(1'b0, 1'b0, 1'b1, "R4 pin low");

      // R9 pin high without ticks: must not advance
      @(negedge clk);
      wake_pin = 1'b1;
      repeat (6) @(negedge clk);
      push(1'b0, 1'b1, "R9 no tick");
      @(negedge clk);
      wake_pin = 1'b0;

      // R4 full window, then R6 pulse with R10 hibernate write inside
      debounce(64, 1'b1, "R4 wake");
      for (int j = 1; j <= 10; j++) do_tick(1'b0, 1'b1, 1'b0, "R6 hold");
      reg_write(8'h20, 32'h1);
      push(1'b1, 1'b0, "R10 ignored");
      for (int j = 11; j < 32; j++) do_tick(1'b0, 1'b1, 1'b0, "R10 hold");
      do_tick(1'b0, 1'b1, 1'b1, "R6 release");

      // R5 pin drops exactly on the Nth tick, then a fresh full window
      enter_sleep();
      for (int i = 1; i < 64; i++) do_tick(1'b1, 1'b0, 1'b1, "R5 window");
      do_tick(1'b0, 1'b0, 1'b1, "R5 drop on last");
      debounce(64, 1'b1, "R5 restart");
      pulse(32, "R6 second pulse");

      // R5 drop early, restart again
      enter_sleep();
      for (int i = 1; i <= 20; i++) do_tick(1'b1, 1'b0, 1'b1, "R5 early");
      do_tick(1'b0, 1'b0, 1'b1, "R5 early drop");
      debounce(64, 1'b1, "R5 early restart");
      pulse(32, "R6 third pulse");

      // R7 zero debounce and zero pulse
      reg_write(8'h24, 32'd0);
      reg_write(8'h28, 32'd0);
      enter_sleep();
      do_tick(1'b0, 1'b0, 1'b1, "R7 pin low");
      do_tick(1'b1, 1'b1, 1'b1, "R7 instant wake");
      do_tick(1'b0, 1'b1, 1'b1, "R7 running");

      // R7 zero debounce with 32-tick pulse, R8 pulse only while powered
      reg_write(8'h28, 32'd32);
      enter_sleep();
      do_tick(1'b1, 1'b1, 1'b0, "R8 wake into hold");
      pulse(32, "R8 pulse");

      repeat (4) @(negedge clk);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule